// File: doc/BRIEF.md
# PLL Lock Status Sequencer

This block holds the configuration of two phase-locked-loop channels and tells the rest of the chip when each channel may be treated as locked. Each channel has one configuration word with a divider, a lock-wait count, an output-range code and an 11-bit multiplier. The analog loop itself is not modelled. Instead, every write to a channel's word clears that channel's lock flag and starts a countdown on the slow-clock tick. When the countdown ends, the lock flag rises, but only if the new setting actually runs the channel.

A setting does not run the channel when the multiplier is zero, when the divider is 0 or 1, or, on channel A, when its source-select bit is clear. In those cases the lock flag stays low and the effective multiply and divide outputs read zero. The slow clock arrives as a single-cycle enable, `slow_tick`, in the main clock domain. Software writes through a small address space and reads the stored words, or a status word that carries both lock flags, through a combinational read port.

Top module: `pll_lock_seq`

## Requirements
- R1: Address 0 selects channel A's word and address 1 selects channel B's. In both words the divider sits at bits 7..0, the lock count at 13..8, the range code at 15..14 and the multiplier at 26..16. Channel A keeps bit 29 as its source select. Channel B keeps bits 29..28 as its USB divider select and drives them on `b_usb_div`. Every other bit reads back as 0.
- R2: A write to a channel word makes that channel's lock flag read 0 from the next cycle on. The other channel's flag is unaffected.
- R3: With a lock count N, the lock flag rises right after the (N+1)-th slow tick that follows the write. A count of 0 therefore locks on the first tick.
- R4: Main-clock cycles without a slow tick do not advance a countdown.
- R5: A write during a running countdown restarts it from the newly written count.
- R6: A multiplier of 0 keeps the lock flag at 0, and both effective outputs are 0.
- R7: A divider of 0 or 1 keeps the lock flag at 0, and both effective outputs are 0.
- R8: On channel A, a source-select bit of 0 keeps the lock flag at 0, and both effective outputs are 0.
- R9: For a running setting, the effective multiply output equals multiplier+1 and the effective divide output equals the divider. The range code is passed through in every case.
- R10: Address 2 reads the status word: bit 0 is A's lock flag, bit 1 is B's, and all other bits are 0. Reads have no side effects. Writes to address 2 or 3 change nothing. Address 3 reads 0.
- R11: After reset, both stored words are 0 and both lock flags are 0.
- R12: If a write and a slow tick arrive in the same cycle, the write wins and the tick is not counted against the new countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register select for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| a_lock | output | 1 | Channel A lock flag |
| a_mul_eff | output | 12 | Channel A effective multiply factor |
| a_div_eff | output | 8 | Channel A effective divide factor |
| a_range | output | 2 | Channel A range code |
| b_lock | output | 1 | Channel B lock flag |
| b_mul_eff | output | 12 | Channel B effective multiply factor |
| b_div_eff | output | 8 | Channel B effective divide factor |
| b_range | output | 2 | Channel B range code |
| b_usb_div | output | 2 | Channel B USB divider select |

## Verification
The bench sweeps every lock count from 0 to 63 on both channels and checks that the flag is still low after N ticks and high after N+1. An off-by-one timer would lock one tick early or late, and a timer that ignores count 0 would hang. It also sweeps all 256 divider codes and a spread of multipliers that includes 0 and 2047. A wrong activity decode would show up as a lock on divider 1 or multiplier 0, or as effective outputs that are not zeroed, and a width slip would show as a wrong multiplier+1 at 2047. Three further cases target ordering errors: a rewrite in mid-countdown, a write on the same cycle as a tick, and writes to the status address. A design that got these wrong would lock early, leak a tick into the new countdown, or clear a lock flag.

// File: rtl/pll_seq_pkg.sv
// Package: shared widths, field positions, register selects and the
// configuration record used by the PLL lock status sequencer.
// Assumes a 32-bit register word and two channels with identical layout.
package pll_seq_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int DIV_W   = 8;
    localparam int CNT_W   = 6;
    localparam int RNG_W   = 2;
    localparam int MUL_W   = 11;
    localparam int EXT_W   = 2;

    // Field positions; the fields are packed low to high with no gaps
    localparam int DIV_LSB = 0;
    localparam int CNT_LSB = DIV_LSB + DIV_W;
    localparam int RNG_LSB = CNT_LSB + CNT_W;
    localparam int MUL_LSB = RNG_LSB + RNG_W;
    localparam int EXT_LSB = 28;

    // Effective multiply output carries multiplier+1, one bit wider
    localparam int MEFF_W  = MUL_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CH_A = 2'd0,
        SEL_CH_B = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [EXT_W-1:0] ext;
        logic [MUL_W-1:0] mul;
        logic [RNG_W-1:0] rng;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } pll_cfg_t;

    // Place a configuration record into its register word; spare bits are 0
    function automatic logic [REG_W-1:0] word_from_cfg(input pll_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[DIV_LSB +: DIV_W] = c.div;
        w[CNT_LSB +: CNT_W] = c.cnt;
        w[RNG_LSB +: RNG_W] = c.rng;
        w[MUL_LSB +: MUL_W] = c.mul;
        w[EXT_LSB +: EXT_W] = c.ext;
        return w;
    endfunction

endpackage

// File: rtl/pll_lock_timer.sv
// Module: per-channel lock countdown on the slow-clock tick.
// A load restarts the count and drops the lock flag. Each tick while busy
// either decrements or, at zero, ends the wait and raises the flag if the
// channel runs. A load has priority over a tick in the same cycle.
// Assumes tick is a one-cycle enable in the clk domain.
module pll_lock_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             en_lock,
    output logic             lock,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             lock_q;

    // Countdown, busy and lock state; load wins over tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            lock_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_cnt;
            busy_q <= 1'b1;
            lock_q <= 1'b0;
        end else if (tick && busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                lock_q <= en_lock;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign lock = lock_q;
    assign busy = busy_q;

    AST_LOAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!lock_q && busy_q)); // R2
    AST_LOCK_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(tick)); // R3
    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(cnt_q) && $stable(lock_q))); // R4
    AST_RESTART_TAKES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_cnt))); // R5
    AST_NO_LOCK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !lock_q); // R3

endmodule

// File: rtl/pll_chan.sv
// Module: one PLL channel. It holds the configuration word, decides
// whether the setting runs the channel and derives the effective factors,
// and drives a lock countdown timer.
// HAS_SRC selects the variant: 1 keeps only the source-select bit of the
// extra field and requires it set, 0 keeps the full 2-bit divider select.
module pll_chan
    import pll_seq_pkg::*;
#(
    parameter bit HAS_SRC = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  pll_cfg_t          wcfg,
    output pll_cfg_t          cfg,
    output logic              lock,
    output logic [MEFF_W-1:0] mul_eff,
    output logic [DIV_W-1:0]  div_eff
);

    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    pll_cfg_t         cfg_q;
    logic [EXT_W-1:0] ext_mask;
    logic             src_ok;
    logic             active;
    logic             busy;

    // Variant: source-select bit gate versus plain divider select
    generate
        if (HAS_SRC) begin : g_src
            assign ext_mask = 2'b10;
            assign src_ok   = cfg_q.ext[1];
        end else begin : g_sel
            assign ext_mask = 2'b11;
            assign src_ok   = 1'b1;
        end
    endgenerate

    // Configuration storage, masked to the bits this variant keeps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q     <= wcfg;
            cfg_q.ext <= wcfg.ext & ext_mask;
        end
    end

    // Run decision and effective factors, zeroed when the channel is stopped
    always_comb begin
        active  = (cfg_q.mul != '0) && (cfg_q.div >= DIV_MIN) && src_ok;
        mul_eff = active ? ({1'b0, cfg_q.mul} + 1'b1) : '0;
        div_eff = active ? cfg_q.div : '0;
    end

    pll_lock_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr),
        .load_cnt (wcfg.cnt),
        .en_lock  (active),
        .lock     (lock),
        .busy     (busy)
    );

    assign cfg = cfg_q;

    AST_LOCK_ONLY_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> active); // R6
    AST_LOCK_HAS_FACTORS: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> ((mul_eff >= MEFF_W'(2)) && (div_eff >= DIV_MIN))); // R9
    AST_STOP_DIVIDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.div < DIV_MIN) |-> (!lock && div_eff == '0)); // R7
    AST_BUSY_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lock); // R2

endmodule

// File: rtl/pll_reg_decode.sv
// Module: register decode. It turns a write into at most one channel
// strobe and muxes the read data. The status select and the unused select
// never produce a strobe. Reads are purely combinational.
module pll_reg_decode
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  word_a,
    input  logic [REG_W-1:0]  word_b,
    input  logic              lock_a,
    input  logic              lock_b,
    output logic              wr_a,
    output logic              wr_b,
    output logic [REG_W-1:0]  rd_data
);

    reg_sel_e sel;

    // Write strobes per channel
    always_comb begin
        sel  = reg_sel_e'(addr);
        wr_a = wr_en && (sel == SEL_CH_A);
        wr_b = wr_en && (sel == SEL_CH_B);
    end

    // Read mux: channel words, status word, zero elsewhere
    always_comb begin
        case (sel)
            SEL_CH_A: rd_data = word_a;
            SEL_CH_B: rd_data = word_b;
            SEL_STAT: rd_data = {{(REG_W-2){1'b0}}, lock_b, lock_a};
            default:  rd_data = '0;
        endcase
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_a, wr_b})); // R10
    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1]) |-> (!wr_a && !wr_b)); // R10

endmodule

// File: rtl/pll_lock_seq.sv
// Module: top of the PLL lock status sequencer. It splits the write word
// into fields, feeds two channel instances (A with source-select gate, B
// with USB divider select) and the register decode, and drives the outputs.
// Assumes slow_tick is already a one-cycle enable in the clk domain.
module pll_lock_seq
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              a_lock,
    output logic [MEFF_W-1:0] a_mul_eff,
    output logic [DIV_W-1:0]  a_div_eff,
    output logic [RNG_W-1:0]  a_range,
    output logic              b_lock,
    output logic [MEFF_W-1:0] b_mul_eff,
    output logic [DIV_W-1:0]  b_div_eff,
    output logic [RNG_W-1:0]  b_range,
    output logic [EXT_W-1:0]  b_usb_div
);

    pll_cfg_t        wcfg;
    pll_cfg_t        cfg_a;
    pll_cfg_t        cfg_b;
    logic            wr_a;
    logic            wr_b;
    logic [REG_W-1:0] word_a;
    logic [REG_W-1:0] word_b;
    logic [2:0]      wr_data_unused;

    // Field split of the incoming write word
    always_comb begin
        wcfg.div = wr_data[DIV_LSB +: DIV_W];
        wcfg.cnt = wr_data[CNT_LSB +: CNT_W];
        wcfg.rng = wr_data[RNG_LSB +: RNG_W];
        wcfg.mul = wr_data[MUL_LSB +: MUL_W];
        wcfg.ext = wr_data[EXT_LSB +: EXT_W];
    end
    assign wr_data_unused = {wr_data[REG_W-1 -: 2], wr_data[MUL_LSB+MUL_W]};

    pll_reg_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .word_a  (word_a),
        .word_b  (word_b),
        .lock_a  (a_lock),
        .lock_b  (b_lock),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .rd_data (rd_data)
    );

    pll_chan #(.HAS_SRC(1'b1)) u_ch_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (slow_tick),
        .wr      (wr_a),
        .wcfg    (wcfg),
        .cfg     (cfg_a),
        .lock    (a_lock),
        .mul_eff (a_mul_eff),
        .div_eff (a_div_eff)
    );

    pll_chan #(.HAS_SRC(1'b0)) u_ch_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (slow_tick),
        .wr      (wr_b),
        .wcfg    (wcfg),
        .cfg     (cfg_b),
        .lock    (b_lock),
        .mul_eff (b_mul_eff),
        .div_eff (b_div_eff)
    );

    // Readback words and pass-through fields
    assign word_a    = word_from_cfg(cfg_a);
    assign word_b    = word_from_cfg(cfg_b);
    assign a_range   = cfg_a.rng;
    assign b_range   = cfg_b.rng;
    assign b_usb_div = cfg_b.ext;

    AST_WRITE_A_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && b_lock && !slow_tick) |=> b_lock); // R2
    AST_STATUS_WRITE_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1] && !slow_tick) |=> ($stable(a_lock) && $stable(b_lock))); // R10

endmodule

// File: tb/sim_pll_lock_seq.sv
module sim_pll_lock_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic        a_lock, b_lock;
    logic [11:0] a_mul_eff, b_mul_eff;
    logic [7:0]  a_div_eff, b_div_eff;
    logic [1:0]  a_range, b_range, b_usb_div;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pll_lock_seq u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .a_lock(a_lock), .a_mul_eff(a_mul_eff), .a_div_eff(a_div_eff), .a_range(a_range),
        .b_lock(b_lock), .b_mul_eff(b_mul_eff), .b_div_eff(b_div_eff), .b_range(b_range),
        .b_usb_div(b_usb_div)
    );

    // Word layout: ext 29..28, mul 26..16, range 15..14, count 13..8, div 7..0
    function automatic logic [31:0] mk(input int d, input int c, input int r,
                                       input int m, input int e);
        return {2'b00, 2'(e), 1'b0, 11'(m), 2'(r), 6'(c), 8'(d)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0;
    endtask

    task automatic tick();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic lk(input int ch);
        return (ch == 0) ? a_lock : b_lock;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 a_lock", a_lock, 0);
        chk("R11 b_lock", b_lock, 0);
        chk("R11 a_mul_eff", a_mul_eff, 0);
        chk("R11 b_div_eff", b_div_eff, 0);
        rd(2'd2, v); chk("R11 status", v, 0);
        rd(2'd0, v); chk("R11 word A", v, 0);
        rd(2'd1, v); chk("R11 word B", v, 0);
        rst_n = 1'b1;

        // R3 sweep of every lock count on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int n = 0; n < 64; n++) begin
                wr(2'(ch), mk(4, n, 1, 5, 2));
                chk("R2 lock cleared by write", lk(ch), 0);
                if (n > 0) begin
                    ticks(n);
                    chk("R3 still waiting after N ticks", lk(ch), 0);
                end
                tick();
                chk("R3 locked after N+1 ticks", lk(ch), 1);
            end
        end

        // R2 other channel unaffected
        wr(2'd0, mk(4, 3, 1, 5, 2));
        chk("R2 A cleared", a_lock, 0);
        chk("R2 B kept", b_lock, 1);
        ticks(4);
        chk("R2 A relocks", a_lock, 1);

        // R4 idle cycles do not count
        wr(2'd0, mk(4, 0, 1, 5, 2));
        repeat (25) @(negedge clk);
        chk("R4 no tick no lock", a_lock, 0);
        tick();
        chk("R4 lock after tick", a_lock, 1);

        // R5 restart in mid-countdown
        wr(2'd0, mk(4, 10, 1, 5, 2));
        ticks(5);
        wr(2'd0, mk(4, 3, 1, 5, 2));
        ticks(3);
        chk("R5 restart not early", a_lock, 0);
        tick();
        chk("R5 restart lock", a_lock, 1);
        wr(2'd1, mk(4, 2, 1, 5, 2));
        ticks(2);
        wr(2'd1, mk(4, 2, 1, 5, 2));
        ticks(2);
        chk("R5 same-count restart", b_lock, 0);
        tick();
        chk("R5 same-count lock", b_lock, 1);

        // R12 write and tick together
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wr_data = mk(4, 0, 1, 5, 2); slow_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; slow_tick = 1'b0; wr_data = 32'd0;
        chk("R12 tick not counted", a_lock, 0);
        tick();
        chk("R12 next tick locks", a_lock, 1);

        // R6 / R9 multiplier spread on channel A, range code 3
        for (int k = 0; k <= 66; k++) begin
            int m;
            m = (k == 66) ? 2047 : k * 31;
            wr(2'd0, mk(9, 0, 3, m, 2));
            tick();
            chk("R6 lock vs multiplier", a_lock, (m != 0));
            chk("R9 mul_eff", a_mul_eff, (m != 0) ? m + 1 : 0);
            chk("R9 div_eff", a_div_eff, (m != 0) ? 9 : 0);
            chk("R9 range", a_range, 3);
        end

        // R7 / R9 all divider codes on channel B, usb select 1
        for (int d = 0; d < 256; d++) begin
            wr(2'd1, mk(d, 0, 2, 7, 1));
            tick();
            chk("R7 lock vs divider", b_lock, (d >= 2));
            chk("R7 div_eff", b_div_eff, (d >= 2) ? d : 0);
            chk("R9 b_mul_eff", b_mul_eff, (d >= 2) ? 8 : 0);
            chk("R1 usb select", b_usb_div, 1);
            chk("R9 b_range", b_range, 2);
        end

        // R8 source select clear on channel A
        wr(2'd0, mk(4, 0, 0, 5, 0));
        tick();
        chk("R8 no lock", a_lock, 0);
        chk("R8 mul_eff", a_mul_eff, 0);
        chk("R8 div_eff", a_div_eff, 0);

        // R1 readback masks
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R1 word A mask", v, 32'h27FF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R1 word B mask", v, 32'h37FF_FFFF);
        chk("R1 usb all ones", b_usb_div, 3);
        wr(2'd0, mk(200, 17, 2, 1234, 2));
        rd(2'd0, v); chk("R1 word A fields", v, mk(200, 17, 2, 1234, 2));

        // R10 status word, ignored writes, side-effect-free reads
        wr(2'd0, mk(4, 0, 0, 5, 2));
        wr(2'd1, mk(4, 0, 0, 5, 0));
        tick();
        rd(2'd2, v); chk("R10 both locked", v, 3);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R10 status write ignored", v, 3);
        rd(2'd0, v); chk("R10 word A after status write", v, mk(4, 0, 0, 5, 2));
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R10 addr 3 write ignored", v, 3);
        rd(2'd1, v); chk("R10 word B after addr 3 write", v, mk(4, 0, 0, 5, 0));
        rd(2'd3, v); chk("R10 addr 3 reads 0", v, 0);
        wr(2'd0, mk(4, 2, 0, 5, 2));
        rd(2'd2, v); chk("R10 only B", v, 2);
        rd(2'd2, v); chk("R10 reread", v, 2);
        ticks(3);
        rd(2'd2, v); chk("R10 both again", v, 3);

        done = 1'b1;
        finish_run();
    end

endmodule